// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block holds the control path of a synchronous pipelined SRAM with byte-granular writes. It samples two address strobes: one from the processor side and one from a cache controller. It also samples three chip selects, a global write enable, a byte write enable and one write select per byte. From these it decides, at every rising clock edge, whether the device reads, writes, keeps running a burst or is deselected. It drives write strobes and per-byte masks into a behavioural memory array. Read data returns through a registered output stage, and a drive-enable signal stands in for the three-state control of the data pins.

A two-bit burst sequencer captures the starting address of each access. When the advance input is asserted in a cycle with no strobe, the sequencer steps the low address bits. The stepping is linear or XOR-interleaved, picked by a static order input. Output enable acts only on the drive-enable signal, so the host can float the bus without disturbing the data pipeline.

Top module: `bsram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `dout_en` is 0 and `dout` is all zeros.
- R2: A read is decoded at an edge when a strobe is valid, `cs1_n`=0, `cs2`=1, `cs3_n`=0, `gwe_n`=1 and `bwe_n`=1. The word at that address is on `dout` after the following edge. Reads may be issued on consecutive edges with no idle cycle.
- R3: With `cs1_n`=1, a low `proc_as_n` has no effect. If `ctrl_as_n` is also high, a selected device treats the cycle as a burst continuation and stays selected.
- R4: After an edge that selects a device that was deselected, `dout_en` is 0 whatever `oe_n` is. From the next edge on, while the device stays selected, `dout_en` equals `!oe_n`.
- R5: A valid strobe with any chip select inactive deselects the device. `dout_en` is 0 right after that edge and stays 0 until a new selection.
- R6: On the edge where a valid `proc_as_n` starts an access, all write inputs are ignored and the cycle reads. A write given in the next cycle (no strobe, `adv_n`=1) stores `din` at the captured address on the second edge.
- R7: `gwe_n`=0 in a cycle whose write inputs are honoured writes all four bytes, whatever `bwe_n` and `bsel_n` are.
- R8: With `gwe_n`=1 and `bwe_n`=0, byte i (bits 8i+7:8i) is written only when `bsel_n[i]`=0. The other bytes keep their previous contents.
- R9: An access started by `ctrl_as_n` alone honours the write inputs on its own edge and stores `din` at the presented address.
- R10: In a no-strobe cycle of a selected device, `adv_n`=0 steps a 2-bit count n (wrapping modulo 4) before the access. Only the low two address bits change. With `lin_order`=1 they are (start+n) mod 4; with `lin_order`=0 they are start XOR n. `adv_n`=1 holds the address.
- R11: A cycle with `gwe_n`=1, `bwe_n`=0 and `bsel_n` all ones writes nothing and reads nothing, so `dout` keeps its value.
- R12: `oe_n` changes `dout_en` within the same cycle, without a clock edge, and never changes `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address presented with a strobe |
| din | input | NBYTES*BYTE_W | Write data |
| proc_as_n | input | 1 | Processor-side address strobe, active low, gated by `cs1_n` |
| ctrl_as_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| gwe_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | NBYTES | Per-byte write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | NBYTES*BYTE_W | Registered read data |
| dout_en | output | 1 | Data drive enable (1 drives the bus) |

## Verification
The assertions assume that every control input is settled around the rising edge and that `lin_order` does not change during a burst. They also assume that reset spans at least one edge. The stimulus changes all inputs only on the falling edge and switches the burst order only between bursts. Before any read, the bench fills every address it reads, because the array has no reset value. The stimulus also keeps the device deselected between groups of operations, so that untracked continuation reads never overwrite a value under check.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    // Width of the burst step counter; bursts span 2**BURST_CNT_W words
    localparam int unsigned BURST_CNT_W = 2;

    // Encoding of the burst order input
    typedef enum logic {
        ORDER_XOR    = 1'b0,
        ORDER_LINEAR = 1'b1
    } burst_order_e;

endpackage

// File: rtl/bsram_burst_seq.sv
module bsram_burst_seq
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned CNT_W  = BURST_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              lin,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] acc_addr
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [CNT_W-1:0] low_bits;

    always_comb begin
        seq_d = seq_q;
        if (load) begin
            seq_d.base = addr_i;
            seq_d.cnt  = '0;
        end else if (step) begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
        if (burst_order_e'(lin) == ORDER_LINEAR) begin
            low_bits = seq_d.base[CNT_W-1:0] + seq_d.cnt;
        end else begin
            low_bits = seq_d.base[CNT_W-1:0] ^ seq_d.cnt;
        end
        acc_addr = {seq_d.base[ADDR_W-1:CNT_W], low_bits};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // Upper address bits captured by a load stay fixed in the next cycle
    AST_BURST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load) && !load)
        |-> (acc_addr[ADDR_W-1:CNT_W] == $past(addr_i[ADDR_W-1:CNT_W]))); // R10

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned NBYTES = 4,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [NBYTES-1:0]        wmask,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [NBYTES*BYTE_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[g]) begin
                lane_mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[g*BYTE_W +: BYTE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned NBYTES = 4,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [NBYTES*BYTE_W-1:0] din,
    input  logic                     proc_as_n,
    input  logic                     ctrl_as_n,
    input  logic                     adv_n,
    input  logic                     lin_order,
    input  logic                     cs1_n,
    input  logic                     cs2,
    input  logic                     cs3_n,
    input  logic                     gwe_n,
    input  logic                     bwe_n,
    input  logic [NBYTES-1:0]        bsel_n,
    input  logic                     oe_n,
    output logic [NBYTES*BYTE_W-1:0] dout,
    output logic                     dout_en
);

    localparam int unsigned DATA_W = NBYTES * BYTE_W;

    typedef struct packed {
        logic              sel;
        logic              out_on;
        logic              rd;
        logic [ADDR_W-1:0] raddr;
        logic [DATA_W-1:0] dout;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              sel_ok;
    logic              proc_go;
    logic              ctrl_go;
    logic              strobe;
    logic              acc_new;
    logic              desel;
    logic              cont;
    logic              rd_req;
    logic              honor_wr;
    logic              do_rd;
    logic              arr_we;
    logic [NBYTES-1:0] wr_mask;
    logic [NBYTES-1:0] arr_mask;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] arr_rdata;

    // Cycle decode from the sampled controls
    always_comb begin
        sel_ok   = !cs1_n && cs2 && !cs3_n;
        proc_go  = !proc_as_n && !cs1_n;
        ctrl_go  = !ctrl_as_n;
        strobe   = proc_go || ctrl_go;
        acc_new  = strobe && sel_ok;
        desel    = strobe && !sel_ok;
        cont     = !strobe && st_q.sel;
        rd_req   = gwe_n && bwe_n;
        if (!gwe_n) begin
            wr_mask = '1;
        end else if (!bwe_n) begin
            wr_mask = ~bsel_n;
        end else begin
            wr_mask = '0;
        end
        honor_wr = cont || (acc_new && !proc_go);
        do_rd    = (acc_new && (proc_go || rd_req)) || (cont && rd_req);
        arr_we   = honor_wr && (|wr_mask);
        arr_mask = honor_wr ? wr_mask : '0;
    end

    bsram_burst_seq #(
        .ADDR_W (ADDR_W),
        .CNT_W  (BURST_CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc_new),
        .step     (cont && !adv_n),
        .lin      (lin_order),
        .addr_i   (addr_i),
        .acc_addr (acc_addr)
    );

    bsram_array #(
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES),
        .BYTE_W (BYTE_W)
    ) u_array (
        .clk   (clk),
        .we    (arr_we),
        .wmask (arr_mask),
        .waddr (acc_addr),
        .wdata (din),
        .raddr (st_q.raddr),
        .rdata (arr_rdata)
    );

    // Next-state computation
    always_comb begin
        st_d = st_q;
        if (acc_new) begin
            st_d.sel = 1'b1;
        end else if (desel) begin
            st_d.sel = 1'b0;
        end
        st_d.out_on = st_q.sel && !desel;
        st_d.rd     = do_rd;
        st_d.raddr  = acc_addr;
        if (st_q.rd) begin
            st_d.dout = arr_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout    = st_q.dout;
    assign dout_en = st_q.out_on && !oe_n;

    AST_CS1_GATES_PROC: assert property (@(posedge clk) disable iff (!rst_n)
        (cs1_n && ctrl_as_n) |=> (st_q.sel == $past(st_q.sel))); // R3

    AST_FIRST_CYCLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_new && !st_q.sel) |=> !dout_en); // R4

    AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> !dout_en); // R5

    AST_PROC_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_as_n && !cs1_n) |-> !arr_we); // R6

    AST_GLOBAL_ALL_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && !gwe_n) |-> (&arr_mask)); // R7

    AST_NO_EMPTY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (arr_mask != '0)); // R11

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.rd |=> $stable(dout)); // R12

endmodule

// File: tb/sim_bsram_ctrl.sv
`timescale 1ns/1ps
module sim_bsram_ctrl;

    localparam int unsigned AW = 6;
    localparam int unsigned NB = 4;
    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] din = '0;
    logic          proc_as_n = 1'b1, ctrl_as_n = 1'b1, adv_n = 1'b1, lin_order = 1'b1;
    logic          cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
    logic          gwe_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
    logic [NB-1:0] bsel_n = '1;
    logic [DW-1:0] dout;
    logic          dout_en;

    bsram_ctrl #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .din(din),
        .proc_as_n(proc_as_n), .ctrl_as_n(ctrl_as_n), .adv_n(adv_n),
        .lin_order(lin_order), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .gwe_n(gwe_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n),
        .dout(dout), .dout_en(dout_en)
    );

    always #10 clk = ~clk;

    typedef struct {
        int          due;
        logic [31:0] data;
        string       req;
    } sb_item_t;

    sb_item_t    sbq[$];
    sb_item_t    item;
    logic [31:0] mdl [64];
    int          ecount = 0;
    int          nchk = 0;
    int          nfail = 0;
    bit          done = 1'b0;

    always @(posedge clk) ecount <= ecount + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare read results in the cycle they are due
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due == ecount) begin
            item = sbq.pop_front();
            check(item.req, dout, item.data);
        end
    end

    always @(posedge clk) begin
        if (ecount > 20000 && !done) begin
            nfail++;
            $display("FAIL watchdog all-requirements actual=%0d expected<20000", ecount);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    function automatic logic [31:0] pat(input int a);
        return 32'h1357_9BDF ^ (a * 32'h0102_0408);
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic gw, input logic bw, input logic [3:0] bs);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++) begin
            if (!gw || (!bw && !bs[i])) r[8*i +: 8] = d[8*i +: 8];
        end
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rest();
        proc_as_n = 1'b1; ctrl_as_n = 1'b1; adv_n = 1'b1;
        cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
        gwe_n = 1'b1; bwe_n = 1'b1; bsel_n = '1;
    endtask

    task automatic op_desel();
        rest();
        ctrl_as_n = 1'b0; cs2 = 1'b0;
        tick();
    endtask

    task automatic op_cwrite(input int a, input logic [31:0] d, input logic gw,
                             input logic bw, input logic [3:0] bs);
        rest();
        ctrl_as_n = 1'b0; addr_i = AW'(a); din = d;
        gwe_n = gw; bwe_n = bw; bsel_n = bs;
        tick();
        mdl[a] = merge(mdl[a], d, gw, bw, bs);
    endtask

    task automatic op_read(input int a, input bit by_proc, input string req);
        rest();
        if (by_proc) proc_as_n = 1'b0; else ctrl_as_n = 1'b0;
        addr_i = AW'(a);
        sbq.push_back('{ecount + 2, mdl[a], req});
        tick();
    endtask

    task automatic op_cont(input logic adv, input int exp_a, input string req);
        rest();
        adv_n = adv;
        sbq.push_back('{ecount + 2, mdl[exp_a], req});
        tick();
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = '0;
        rest();
        tick(); tick();
        check("R1 dout_en in reset", 32'(dout_en), 32'd0);
        check("R1 dout in reset", dout, 32'd0);
        rst_n = 1'b1;
        tick();
        check("R1 dout_en after reset", 32'(dout_en), 32'd0);

        // R9: fill by controller-strobe global writes
        for (int a = 0; a < 16; a++) op_cwrite(a, pat(a), 1'b0, 1'b1, 4'hF);
        op_desel();

        // R4 / R2: read from deselect, then back-to-back reads
        op_read(5, 1'b0, "R9 R2 read 5");
        check("R4 first cycle hi-z", 32'(dout_en), 32'd0);
        op_read(6, 1'b1, "R2 read 6");
        check("R4 driven after first cycle", 32'(dout_en), 32'd1);
        op_read(7, 1'b1, "R2 read 7");
        op_read(3, 1'b1, "R2 read 3");

        // R5: deselect floats the outputs at once
        op_desel();
        check("R5 hi-z after deselect", 32'(dout_en), 32'd0);
        op_desel();
        check("R5 stays hi-z", 32'(dout_en), 32'd0);

        // R3: processor strobe ignored while cs1_n is high
        op_read(2, 1'b0, "R3 setup read 2");
        rest();
        proc_as_n = 1'b0; cs1_n = 1'b1; addr_i = AW'(9);
        sbq.push_back('{ecount + 2, mdl[2], "R3 continuation of 2"});
        tick();
        check("R3 still selected", 32'(dout_en), 32'd1);

        // R6: processor-strobe write, controls ignored on first edge
        rest();
        proc_as_n = 1'b0; addr_i = AW'(9); gwe_n = 1'b0; din = 32'hDEAD_BEEF;
        sbq.push_back('{ecount + 2, mdl[9], "R6 first cycle reads"});
        tick();
        rest();
        bwe_n = 1'b0; bsel_n = 4'b1110; din = 32'h1122_3344;
        tick();
        mdl[9] = merge(mdl[9], 32'h1122_3344, 1'b1, 1'b0, 4'b1110);
        op_desel();
        op_read(9, 1'b0, "R6 second-edge write");

        // R8: byte write of bytes 0 and 2
        op_cwrite(4, 32'hCAFE_F00D, 1'b1, 1'b0, 4'b1010);
        op_read(4, 1'b0, "R8 byte merge");

        // R7: global write overrides byte controls
        op_cwrite(8, 32'h0BAD_CAFE, 1'b0, 1'b0, 4'b1111);
        op_read(8, 1'b0, "R7 global write");

        // R10: linear burst from 13
        lin_order = 1'b1;
        op_read(13, 1'b1, "R10 lin start");
        op_cont(1'b0, 14, "R10 lin step1");
        op_cont(1'b0, 15, "R10 lin step2");
        op_cont(1'b0, 12, "R10 lin wrap");
        op_cont(1'b1, 12, "R10 lin hold");
        // R10: interleaved burst from 13
        lin_order = 1'b0;
        op_read(13, 1'b1, "R10 xor start");
        op_cont(1'b0, 12, "R10 xor step1");
        op_cont(1'b0, 15, "R10 xor step2");
        op_cont(1'b0, 14, "R10 xor step3");
        op_cont(1'b0, 13, "R10 xor wrap");
        lin_order = 1'b1;

        // R11: write with no byte selected does nothing
        op_desel();
        op_read(10, 1'b0, "R11 setup read 10");
        rest();
        ctrl_as_n = 1'b0; addr_i = AW'(11); bwe_n = 1'b0; din = 32'hFFFF_FFFF;
        tick();
        op_desel();
        check("R11 dout kept", dout, mdl[10]);
        op_read(11, 1'b0, "R11 array untouched");

        // R12: output enable is combinational and leaves data alone
        op_read(1, 1'b1, "R12 read 1");
        op_read(1, 1'b1, "R12 read 1 again");
        check("R12 driven", 32'(dout_en), 32'd1);
        oe_n = 1'b1;
        #1;
        check("R12 oe high floats", 32'(dout_en), 32'd0);
        check("R12 data unchanged", dout, mdl[1]);
        oe_n = 1'b0;
        #1;
        check("R12 oe low drives", 32'(dout_en), 32'd1);
        @(negedge clk);

        op_desel();
        tick(); tick();
        check("R2 scoreboard drained", 32'(sbq.size()), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule